// File: doc/BRIEF.md
# Reset sequencer with synchronous sequence and asynchronous escape

This block decides when a small microcontroller's internal logic is held in reset and why. It accepts three kinds of reset request. The first is an active-low external pin, which passes through a synchronizer and a noise filter. The other two are a software request and a watchdog request.

Every accepted request starts a fixed-length synchronous sequence of `SEQ_LEN` clock cycles. One clock cycle is one time unit.

A hardware reset has two further rules:
- At the end of the sequence the filtered pin is sampled. If it is still asserted, the reset is classified as long and held until the pin is released. Otherwise it is classified as short and released at once.
- During a hardware reset the block watches a digital sense input that reports whether an external hold-up capacitor is still charged. If that input reads low while the filtered pin is active, the block drops at once into asynchronous reset. It stays there until both the pin and the sense input are released.

Software and watchdog sequences never look at the sense input. Outside a hardware reset the sense input has no effect at all.

A configuration write port holds a bidirectional-reset enable at bit 3. When this bit is set, the next software or watchdog sequence also drives the reset pin low for its full length. Every reset clears the bit. While the filtered pin is asserted, the block enables the weak pull-down on the sense node. A status field reports the source of the most recent reset.

Top module: `reset_sequencer`

## Requirements
- R1: A low pulse on `ext_rst_n` lasting at most `FLT_MIN` clock cycles never asserts `pd_en` or `sys_rst`.
- R2: A low level on `ext_rst_n` held for at least `FLT_ACC` cycles is accepted. `pd_en` is high exactly while the filtered pin is asserted. A hardware reset sequence then starts.
- R3: A software or watchdog request sampled while idle raises `sys_rst` and `rst_out` from the next cycle for exactly `SEQ_LEN` cycles. `last_src` then reads 3 (software) or 4 (watchdog).
- R4: A hardware reset whose filtered pin is released before the end of the sequence lasts exactly `SEQ_LEN` cycles. It sets `last_src` to 1 (short) and clears `long_rst`.
- R5: A hardware reset whose filtered pin is still asserted at the end of the sequence sets `last_src` to 2 (long) and `long_rst` to 1. It holds `sys_rst` until the filtered pin deasserts.
- R6: While the filtered pin is asserted during a hardware reset, a low `sense_in` moves the block to asynchronous reset. `sys_rst` is asserted in the same cycle and `last_src` reads 5. `sys_rst` stays high until both `ext_rst_n` and `sense_in` are high again, and then the block returns to idle.
- R7: `sense_in` has no effect while the filtered pin is inactive. This covers idle and software or watchdog sequences, which complete with their normal length and source code.
- R8: When requests arrive in the same idle cycle, the hardware pin wins over the watchdog, and the watchdog wins over software.
- R9: A configuration write (`cfg_we`) while idle loads `bidir_en` from bit 3 of `cfg_wdata`. All other bits have no effect on it.
- R10: A software or watchdog sequence started with `bidir_en` set holds `pin_drive` high for exactly its `SEQ_LEN` cycles. A hardware reset never raises `pin_drive`. The start of any reset clears `bidir_en`.
- R11: After `por_n` all outputs are low and `last_src` reads 0.
- R12: A software or watchdog request that arrives during an active sequence neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one cycle is one time unit |
| por_n | input | 1 | Power-on reset of the block itself, active low |
| ext_rst_n | input | 1 | Raw external reset pin, active low |
| sense_in | input | 1 | Digital sense of the hold-up capacitor, high while charged |
| sw_req | input | 1 | Software reset request, one-cycle pulse |
| wdt_req | input | 1 | Watchdog reset request, one-cycle pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data; bit 3 is the bidirectional-reset enable |
| sys_rst | output | 1 | Internal system reset, active high |
| rst_out | output | 1 | Registered reset-out flag |
| pd_en | output | 1 | Weak pull-down enable on the sense node |
| pin_drive | output | 1 | Drive the reset pin low |
| long_rst | output | 1 | Last hardware reset was classified long |
| last_src | output | 3 | Last reset source: 0 none, 1 short, 2 long, 3 software, 4 watchdog, 5 asynchronous |
| bidir_en | output | 1 | Current bidirectional-reset enable |

## Verification
The bench builds the block with `SEQ_LEN` = 32, `FLT_MIN` = 3 and `FLT_ACC` = 8. A sequence therefore ends in a few dozen cycles, so long holds, releases inside the sequence and asynchronous escapes all fit in a short run. The narrow filter window lets random glitches up to the rejection width be compared directly against pulses just past the acceptance width.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_ASYNC = 2'd3
    } rsq_state_e;

    typedef enum logic [1:0] {
        ORG_HW  = 2'd0,
        ORG_SW  = 2'd1,
        ORG_WDT = 2'd2
    } rsq_origin_e;

    typedef enum logic [2:0] {
        SRC_NONE     = 3'd0,
        SRC_HW_SHORT = 3'd1,
        SRC_HW_LONG  = 3'd2,
        SRC_SW       = 3'd3,
        SRC_WDT      = 3'd4,
        SRC_ASYNC    = 3'd5
    } rsq_src_e;

    localparam int unsigned BIDIR_BIT = 3;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned TOTAL = W * STAGES;

    logic [TOTAL-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb pipe_d = d;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[TOTAL-W-1:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[TOTAL-1 -: W];
endmodule

// File: rtl/rsq_filter.sv
module rsq_filter #(
    parameter int unsigned MIN_W = 2,
    parameter int unsigned ACC_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic rst_act
);
    localparam int unsigned THR = (MIN_W + 1 + ACC_W) / 2;
    localparam int unsigned CW  = $clog2(THR + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t  f_d, f_q;
    logic  pin_s;
    logic  in_act;

    rsq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_n),
        .q     (pin_s)
    );

    assign in_act = ~pin_s;

    always_comb begin
        f_d = f_q;
        if (in_act != f_q.act) begin
            if (f_q.cnt == CW'(THR - 1)) begin
                f_d.act = in_act;
                f_d.cnt = '0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end else begin
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rst_act = f_q.act;
endmodule

// File: rtl/rsq_seq.sv
module rsq_seq
    import rsq_pkg::*;
#(
    parameter int unsigned SEQ_LEN = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_act,
    input  logic       sense_ok,
    input  logic       sw_req,
    input  logic       wdt_req,
    input  logic       cfg_we,
    input  logic       cfg_bidir,
    output logic       sys_rst,
    output logic       rst_out,
    output logic       pin_drive,
    output logic       long_rst,
    output logic [2:0] last_src,
    output logic       bidir_en
);
    localparam int unsigned CNTW = $clog2(SEQ_LEN + 1);

    typedef struct packed {
        rsq_state_e     state;
        rsq_origin_e    origin;
        logic [CNTW-1:0] cnt;
        logic           drive;
        logic           bidir;
        logic           long_f;
        rsq_src_e       src;
    } seq_t;

    seq_t s_d, s_q;
    logic sense_window;
    logic async_hit;
    logic seq_end;

    always_comb begin
        sense_window = rst_act & ((s_q.state == ST_IDLE) ||
                                  (s_q.state == ST_HOLD) ||
                                  ((s_q.state == ST_SYNC) && (s_q.origin == ORG_HW)));
        async_hit = sense_window & ~sense_ok;
        seq_end   = (s_q.cnt == CNTW'(SEQ_LEN - 1));

        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (async_hit) begin
                    s_d.state  = ST_ASYNC;
                    s_d.src    = SRC_ASYNC;
                    s_d.long_f = 1'b0;
                    s_d.bidir  = 1'b0;
                    s_d.drive  = 1'b0;
                end else if (rst_act) begin
                    s_d.state  = ST_SYNC;
                    s_d.origin = ORG_HW;
                    s_d.cnt    = '0;
                    s_d.bidir  = 1'b0;
                    s_d.drive  = 1'b0;
                end else if (wdt_req) begin
                    s_d.state  = ST_SYNC;
                    s_d.origin = ORG_WDT;
                    s_d.cnt    = '0;
                    s_d.drive  = s_q.bidir;
                    s_d.bidir  = 1'b0;
                end else if (sw_req) begin
                    s_d.state  = ST_SYNC;
                    s_d.origin = ORG_SW;
                    s_d.cnt    = '0;
                    s_d.drive  = s_q.bidir;
                    s_d.bidir  = 1'b0;
                end else if (cfg_we) begin
                    s_d.bidir  = cfg_bidir;
                end
            end
            ST_SYNC: begin
                if (async_hit) begin
                    s_d.state  = ST_ASYNC;
                    s_d.src    = SRC_ASYNC;
                    s_d.long_f = 1'b0;
                    s_d.drive  = 1'b0;
                    s_d.cnt    = '0;
                end else if (seq_end) begin
                    s_d.cnt    = '0;
                    s_d.drive  = 1'b0;
                    s_d.long_f = 1'b0;
                    unique case (s_q.origin)
                        ORG_HW: begin
                            if (rst_act) begin
                                s_d.state  = ST_HOLD;
                                s_d.src    = SRC_HW_LONG;
                                s_d.long_f = 1'b1;
                            end else begin
                                s_d.state  = ST_IDLE;
                                s_d.src    = SRC_HW_SHORT;
                            end
                        end
                        ORG_WDT: begin
                            s_d.state = ST_IDLE;
                            s_d.src   = SRC_WDT;
                        end
                        default: begin
                            s_d.state = ST_IDLE;
                            s_d.src   = SRC_SW;
                        end
                    endcase
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (async_hit) begin
                    s_d.state  = ST_ASYNC;
                    s_d.src    = SRC_ASYNC;
                    s_d.long_f = 1'b0;
                end else if (!rst_act) begin
                    s_d.state  = ST_IDLE;
                end
            end
            default: begin
                if (!rst_act && sense_ok) begin
                    s_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, origin: ORG_HW, cnt: '0, drive: 1'b0,
                     bidir: 1'b0, long_f: 1'b0, src: SRC_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign sys_rst   = (s_q.state != ST_IDLE) | async_hit;
    assign rst_out   = (s_q.state != ST_IDLE);
    assign pin_drive = s_q.drive;
    assign long_rst  = s_q.long_f;
    assign last_src  = s_q.src;
    assign bidir_en  = s_q.bidir;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rsq_pkg::*;
#(
    parameter int unsigned SEQ_LEN = 1024,
    parameter int unsigned FLT_MIN = 2,
    parameter int unsigned FLT_ACC = 20,
    parameter int unsigned CFG_W   = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_n,
    input  logic             sense_in,
    input  logic             sw_req,
    input  logic             wdt_req,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             sys_rst,
    output logic             rst_out,
    output logic             pd_en,
    output logic             pin_drive,
    output logic             long_rst,
    output logic [2:0]       last_src,
    output logic             bidir_en
);
    logic rst_act;
    logic sense_s;

    rsq_filter #(.MIN_W(FLT_MIN), .ACC_W(FLT_ACC)) u_filter (
        .clk     (clk),
        .rst_n   (por_n),
        .pin_n   (ext_rst_n),
        .rst_act (rst_act)
    );

    rsq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_sense_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (sense_in),
        .q     (sense_s)
    );

    rsq_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (por_n),
        .rst_act   (rst_act),
        .sense_ok  (sense_s),
        .sw_req    (sw_req),
        .wdt_req   (wdt_req),
        .cfg_we    (cfg_we),
        .cfg_bidir (cfg_wdata[BIDIR_BIT]),
        .sys_rst   (sys_rst),
        .rst_out   (rst_out),
        .pin_drive (pin_drive),
        .long_rst  (long_rst),
        .last_src  (last_src),
        .bidir_en  (bidir_en)
    );

    assign pd_en = rst_act;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
    parameter int unsigned SEQ_LEN = 1024
) (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst,
    input logic       rst_out,
    input logic       pd_en,
    input logic       pin_drive,
    input logic       long_rst,
    input logic [2:0] last_src,
    input logic       bidir_en
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       run_q <= '0;
        else if (rst_out) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    a_r3_sw_wdt_len: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rst_out) && (last_src == 3'd3 || last_src == 3'd4)) |-> (run_q == SEQ_LEN));

    a_r4_min_len: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rst_out) && last_src != 3'd5) |-> (run_q >= SEQ_LEN));

    a_r5_long_release: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rst_out) && long_rst) |-> !$past(pd_en));

    a_r6_async_holds: assert property (@(posedge clk) disable iff (!por_n)
        (last_src == 3'd5 && rst_out) |-> sys_rst);

    a_r10_drive_inside: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive |-> (rst_out && sys_rst));

    a_r10_bidir_cleared: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out) |-> !bidir_en);
endmodule

bind reset_sequencer rsq_checker #(.SEQ_LEN(SEQ_LEN)) u_rsq_checker (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst   (sys_rst),
    .rst_out   (rst_out),
    .pd_en     (pd_en),
    .pin_drive (pin_drive),
    .long_rst  (long_rst),
    .last_src  (last_src),
    .bidir_en  (bidir_en)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_LEN    = 32;
    localparam int FLT_MIN    = 3;
    localparam int FLT_ACC    = 8;
    localparam int CFG_W      = 16;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             ext_rst_n = 1'b1;
    logic             sense_in = 1'b1;
    logic             sw_req = 1'b0;
    logic             wdt_req = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             sys_rst, rst_out, pd_en, pin_drive, long_rst, bidir_en;
    logic [2:0]       last_src;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_sequencer #(
        .SEQ_LEN(SEQ_LEN), .FLT_MIN(FLT_MIN), .FLT_ACC(FLT_ACC), .CFG_W(CFG_W)
    ) u_reset_sequencer (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sense_in(sense_in),
        .sw_req(sw_req), .wdt_req(wdt_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sys_rst(sys_rst), .rst_out(rst_out), .pd_en(pd_en), .pin_drive(pin_drive),
        .long_rst(long_rst), .last_src(last_src), .bidir_en(bidir_en)
    );

    function automatic int exp_src(input bit is_wdt);
        return is_wdt ? 4 : 3;
    endfunction

    function automatic int exp_hw_src(input bit held_past_end);
        return held_past_end ? 2 : 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(output int n, output int drv);
        n = 0;
        drv = 0;
        while (sys_rst && n < 5000) begin
            n++;
            if (pin_drive) drv++;
            tick();
        end
    endtask

    task automatic wait_rise(output bit seen);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            if (sys_rst) begin
                seen = 1;
                break;
            end
            tick();
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 200; i++) begin
            if (!rst_out && !pd_en && !sys_rst) break;
            tick();
        end
        tick(4);
    endtask

    task automatic soft_pulse(input bit do_sw, input bit do_wdt);
        sw_req  = do_sw;
        wdt_req = do_wdt;
        tick();
        sw_req  = 1'b0;
        wdt_req = 1'b0;
    endtask

    task automatic cfg_write(input logic [CFG_W-1:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic glitch(input int w);
        int hits;
        hits = 0;
        ext_rst_n = 1'b0;
        tick(w);
        ext_rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (pd_en || sys_rst) hits++;
            tick();
        end
        chk($sformatf("R1 glitch width %0d", w), hits, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n, drv, hold, r;
        bit seen, kind;
        r = $urandom(32'h00C0FFEE);

        tick(3);
        // R11 reset state
        chk("R11 sys_rst", sys_rst, 0);
        chk("R11 rst_out", rst_out, 0);
        chk("R11 pd_en", pd_en, 0);
        chk("R11 pin_drive", pin_drive, 0);
        chk("R11 last_src", last_src, 0);
        chk("R11 bidir_en", bidir_en, 0);
        chk("R11 long_rst", long_rst, 0);
        por_n = 1'b1;
        tick(3);

        // R3 software reset, exact length
        soft_pulse(1, 0);
        chk("R3 sys_rst next cycle", sys_rst, 1);
        chk("R3 rst_out next cycle", rst_out, 1);
        count_high(n, drv);
        chk("R3 sw length", n, SEQ_LEN);
        chk("R3 sw source", last_src, exp_src(0));
        chk("R3 rst_out released", rst_out, 0);
        tick(3);

        // R3 watchdog reset
        soft_pulse(0, 1);
        count_high(n, drv);
        chk("R3 wdt length", n, SEQ_LEN);
        chk("R3 wdt source", last_src, exp_src(1));
        tick(3);

        // R8 simultaneous software and watchdog
        soft_pulse(1, 1);
        count_high(n, drv);
        chk("R8 wdt beats sw", last_src, 4);
        tick(3);

        // R12 second request mid-sequence does not extend
        soft_pulse(1, 0);
        tick(9);
        soft_pulse(0, 1);
        count_high(n, drv);
        chk("R12 no restart", n, SEQ_LEN - 10);
        chk("R12 source kept", last_src, 3);
        tick(3);

        // R1 glitches at the rejection limit
        glitch(1);
        glitch(FLT_MIN);

        // R2 + R4 hardware short reset
        ext_rst_n = 1'b0;
        fork begin tick(FLT_ACC + 2); ext_rst_n = 1'b1; end join_none
        wait_rise(seen);
        chk("R2 accepted", int'(seen), 1);
        chk("R2 pd_en while asserted", pd_en, 1);
        count_high(n, drv);
        chk("R4 short length", n, SEQ_LEN);
        chk("R4 short source", last_src, exp_hw_src(0));
        chk("R4 long_rst clear", long_rst, 0);
        chk("R2 pd_en released", pd_en, 0);
        settle();

        // R5 long reset, R10 no pin drive on hardware reset, R10 bidir cleared
        cfg_write(16'h0008);
        ext_rst_n = 1'b0;
        hold = SEQ_LEN + 30;
        fork begin tick(hold); ext_rst_n = 1'b1; end join_none
        wait_rise(seen);
        count_high(n, drv);
        chk("R5 long source", last_src, exp_hw_src(1));
        chk("R5 long flag", long_rst, 1);
        chk("R5 held beyond sequence", int'(n > SEQ_LEN + 20), 1);
        chk("R5 pd_en low at release", pd_en, 0);
        chk("R10 no drive on hw reset", drv, 0);
        chk("R10 bidir cleared by hw", bidir_en, 0);
        settle();

        // R9 configuration bit position
        cfg_write(16'hFFF7);
        chk("R9 other bits ignored", bidir_en, 0);
        cfg_write(16'h0008);
        chk("R9 bit3 sets", bidir_en, 1);

        // R10 watchdog drives pin, bit cleared
        soft_pulse(0, 1);
        chk("R10 bidir cleared at start", bidir_en, 0);
        count_high(n, drv);
        chk("R10 drive length", drv, SEQ_LEN);
        chk("R10 drive off after", pin_drive, 0);
        tick(3);
        soft_pulse(1, 0);
        count_high(n, drv);
        chk("R10 no drive when bit clear", drv, 0);
        tick(3);

        // R7 sense low while idle and during software reset
        sense_in = 1'b0;
        tick(15);
        chk("R7 idle sense ignored", sys_rst, 0);
        chk("R7 idle source unchanged", last_src, 3);
        soft_pulse(1, 0);
        count_high(n, drv);
        chk("R7 sw length with sense low", n, SEQ_LEN);
        chk("R7 sw source with sense low", last_src, 3);
        sense_in = 1'b1;
        tick(4);

        // R6 asynchronous escape during hardware reset
        ext_rst_n = 1'b0;
        wait_rise(seen);
        tick(4);
        sense_in = 1'b0;
        tick(6);
        chk("R6 async source", last_src, 5);
        chk("R6 async sys_rst", sys_rst, 1);
        n = 0;
        for (int i = 0; i < SEQ_LEN + 10; i++) begin
            if (!sys_rst) n++;
            tick();
        end
        chk("R6 held while both low", n, 0);
        ext_rst_n = 1'b1;
        tick(20);
        chk("R6 held while sense low", sys_rst, 1);
        sense_in = 1'b1;
        tick(10);
        chk("R6 released", sys_rst, 0);
        chk("R6 back to idle", rst_out, 0);
        settle();

        // random mix of software, watchdog and glitches
        for (int it = 0; it < 20; it++) begin
            r = $urandom % 3;
            if (r == 2) begin
                glitch(1 + ($urandom % FLT_MIN));
            end else begin
                kind = (r == 1);
                soft_pulse(!kind, kind);
                count_high(n, drv);
                chk("R3 random length", n, SEQ_LEN);
                chk("R3 random source", last_src, exp_src(kind));
                tick(1 + ($urandom % 5));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule